// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for a PHY on the management side of an Ethernet MAC. The host talks to it through two registers: a command register and a data register. Writing a command names a PHY address, a PHY register number and a direction. When the address matches the configured PHY address, the command is carried out at the same clock edge.

A read command copies the selected PHY register into the data register. A write command moves the low 16 bits of the data register into the PHY control register. The host can write the data register directly, which is how it stages the value for a write command.

The model holds four PHY registers: control, status and two fixed identifier words. The status link bit is not stored; it is taken live from the `link_up` input. Since every command finishes within one cycle, the busy flag in the command register always reads back as clear.

Top module: `phy_mgmt_model`

## Requirements
- R1: After synchronous reset, the command and data registers read 0 and the PHY control register holds 0x3100: 100 Mb/s on bit 13, autonegotiation enabled on bit 12, full duplex on bit 8.
- R2: The command word carries the PHY address in bits 15:12, the register number in bits 7:4, write (1) or read (0) in bit 1 and busy in bit 0. On a command write the stored word equals the written word with bit 0 forced to 0.
- R3: A command whose address differs from `phy_addr_cfg` changes neither the data register nor the control register.
- R4: A read command to register 0 loads the control value, zero-extended, into the data register. The value is visible on the cycle after the command write.
- R5: A read of register 1 returns 0xFE28 (bits 15 to 9, 5 and 3 set), with bit 2 set when `link_up` is 1.
- R6: Reads of register 2 return 0x0044 and reads of register 3 return 0x1400.
- R7: A read of any register from 4 to 15 loads 0 into the data register.
- R8: A write command to register 0 with data bit 15 clear stores the low 16 data bits with bits 15 and 9 forced to 0.
- R9: A write command to register 0 with data bit 15 set restores the control value 0x3100. The link bit still follows the input afterwards.
- R10: Write commands to registers other than 0 change no PHY register.
- R11: A host write to the data register (host_sel = 1) stores the full word, and the word reads back on the next cycle.
- R12: Status bit 2 follows `link_up` at the time of every status read, with no stored copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Live link state from the line side |
| phy_addr_cfg | input | 4 | PHY address this model answers to |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects command register, 1 selects data register |
| host_wdata | input | BUS_W | Host write data |
| cmd_rdata | output | BUS_W | Current command register |
| data_rdata | output | BUS_W | Current data register |

## Verification
The assertions assume at most one host write per cycle. They also assume that `host_wdata` and `host_sel` are settled whenever `host_we` is high, and that `phy_addr_cfg` does not change while commands are in flight. The bench meets these conditions by driving every input at the falling edge. It pulses the write strobe for exactly one cycle and sets the configured address once, before reset is released. It changes `link_up` only between commands, so each status read sees a known link state.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int PHY_W     = 16;
    localparam int FLD_W     = 4;
    localparam int RESET_BIT = 15;
    localparam int LINK_BIT  = 2;

    localparam logic [PHY_W-1:0] CTRL_DEFAULT  = 16'h3100;
    localparam logic [PHY_W-1:0] STAT_FIXED    = 16'hFE28;
    localparam logic [PHY_W-1:0] ID_WORD_HI    = 16'h0044;
    localparam logic [PHY_W-1:0] ID_WORD_LO    = 16'h1400;
    localparam logic [PHY_W-1:0] CTRL_AUTO_CLR = 16'h8200;

    localparam logic [FLD_W-1:0] IDX_CTRL  = 4'd0;
    localparam logic [FLD_W-1:0] IDX_STAT  = 4'd1;
    localparam logic [FLD_W-1:0] IDX_ID_HI = 4'd2;
    localparam logic [FLD_W-1:0] IDX_ID_LO = 4'd3;

    typedef enum logic {HSEL_CMD = 1'b0, HSEL_DATA = 1'b1} host_sel_e;

    typedef struct packed {
        logic [FLD_W-1:0] phy;
        logic [FLD_W-1:0] idx;
        logic             wr;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t unpack_cmd(input logic [PHY_W-1:0] w);
        mgmt_cmd_t c;
        c.phy = w[15:12];
        c.idx = w[7:4];
        c.wr  = w[1];
        return c;
    endfunction
endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
    import phy_mgmt_pkg::*;
(
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [PHY_W-1:0] cmd_word,
    input  logic [FLD_W-1:0] phy_addr_cfg,
    output logic             issue,
    output mgmt_cmd_t        cmd
);
    always_comb begin
        cmd   = unpack_cmd(cmd_word);
        issue = host_we && (host_sel == HSEL_CMD) && (cmd.phy == phy_addr_cfg);
    end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PHY_W-1:0] wr_val,
    output logic [PHY_W-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_DEFAULT;
        end else if (wr_en) begin
            if (wr_val[RESET_BIT]) begin
                ctrl_q <= CTRL_DEFAULT;
            end else begin
                ctrl_q <= wr_val & ~CTRL_AUTO_CLR;
            end
        end
    end
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_mgmt_pkg::*;
(
    input  logic [FLD_W-1:0] idx,
    input  logic [PHY_W-1:0] ctrl_q,
    input  logic             link_up,
    output logic [PHY_W-1:0] rd_val
);
    logic [PHY_W-1:0] status_w;

    always_comb begin
        status_w           = STAT_FIXED;
        status_w[LINK_BIT] = link_up;
        case (idx)
            IDX_CTRL:  rd_val = ctrl_q;
            IDX_STAT:  rd_val = status_w;
            IDX_ID_HI: rd_val = ID_WORD_HI;
            IDX_ID_LO: rd_val = ID_WORD_LO;
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic [3:0]       phy_addr_cfg,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] cmd_rdata,
    output logic [BUS_W-1:0] data_rdata
);
    localparam int PAD_W = BUS_W - PHY_W;

    logic             issue;
    mgmt_cmd_t        cmd;
    logic             ctrl_we;
    logic [PHY_W-1:0] ctrl_q;
    logic [PHY_W-1:0] rd_val;
    logic [BUS_W-1:0] cmd_q;
    logic [BUS_W-1:0] data_q;

    phy_cmd_decode u_dec (
        .host_we      (host_we),
        .host_sel     (host_sel),
        .cmd_word     (host_wdata[PHY_W-1:0]),
        .phy_addr_cfg (phy_addr_cfg),
        .issue        (issue),
        .cmd          (cmd)
    );

    assign ctrl_we = issue && cmd.wr && (cmd.idx == IDX_CTRL);

    phy_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_we),
        .wr_val (data_q[PHY_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    phy_read_mux u_mux (
        .idx     (cmd.idx),
        .ctrl_q  (ctrl_q),
        .link_up (link_up),
        .rd_val  (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (host_we) begin
            if (host_sel == HSEL_CMD) begin
                cmd_q <= {host_wdata[BUS_W-1:1], 1'b0};
                if (issue && !cmd.wr) begin
                    data_q <= {{PAD_W{1'b0}}, rd_val};
                end
            end else begin
                data_q <= host_wdata;
            end
        end
    end

    assign cmd_rdata  = cmd_q;
    assign data_rdata = data_q;
endmodule

// File: rtl/phy_mgmt_model_chk.sv
module phy_mgmt_model_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             link_up,
    input logic [3:0]       phy_addr_cfg,
    input logic             host_we,
    input logic             host_sel,
    input logic [BUS_W-1:0] host_wdata,
    input logic [BUS_W-1:0] cmd_rdata,
    input logic [BUS_W-1:0] data_rdata
);
    logic cmd_wr, hit_rd, miss;
    assign cmd_wr = host_we && !host_sel;
    assign hit_rd = cmd_wr && host_wdata[15:12] == phy_addr_cfg && !host_wdata[1];
    assign miss   = cmd_wr && host_wdata[15:12] != phy_addr_cfg;

    // R2: stored command never shows busy
    a_r2_busy_low: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_rdata[0] == 1'b0);
    // R2: stored command keeps all other bits
    a_r2_cmd_kept: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_rdata[BUS_W-1:1] == $past(host_wdata[BUS_W-1:1]));
    // R3: foreign address leaves data alone
    a_r3_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
        miss |=> data_rdata == $past(data_rdata));
    // R5: status read value
    a_r5_status: assert property (@(posedge clk) disable iff (rst)
        hit_rd && host_wdata[7:4] == 4'd1 |=>
        data_rdata == {{(BUS_W-16){1'b0}}, 16'hFE28 | {13'd0, $past(link_up), 2'b00}});
    // R6: identifier words
    a_r6_id_hi: assert property (@(posedge clk) disable iff (rst)
        hit_rd && host_wdata[7:4] == 4'd2 |=> data_rdata == 32'h0044);
    a_r6_id_lo: assert property (@(posedge clk) disable iff (rst)
        hit_rd && host_wdata[7:4] == 4'd3 |=> data_rdata == 32'h1400);
    // R7: unsupported registers read zero
    a_r7_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        hit_rd && host_wdata[7:4] >= 4'd4 |=> data_rdata == '0);
    // R11: direct data write
    a_r11_data_write: assert property (@(posedge clk) disable iff (rst)
        host_we && host_sel |=> data_rdata == $past(host_wdata));
endmodule

bind phy_mgmt_model phy_mgmt_model_chk #(.BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .link_up      (link_up),
    .phy_addr_cfg (phy_addr_cfg),
    .host_we      (host_we),
    .host_sel     (host_sel),
    .host_wdata   (host_wdata),
    .cmd_rdata    (cmd_rdata),
    .data_rdata   (data_rdata)
);

// File: tb/phy_mgmt_model_bench.sv
module phy_mgmt_model_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] MY_PHY = 4'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic [3:0]  phy_addr_cfg = MY_PHY;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_rdata, data_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    bit          q_sel[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_model u_phy_mgmt_model (
        .clk(clk), .rst(rst), .link_up(link_up), .phy_addr_cfg(phy_addr_cfg),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata)
    );

    function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] r, input bit wr);
        return {16'h0, a, 4'h0, r, 2'b00, wr, 1'b0};
    endfunction

    task automatic host_write(input bit sel, input logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic expect_val(input bit sel, input logic [31:0] e, input string tag);
        q_sel.push_back(sel); q_exp.push_back(e); q_tag.push_back(tag);
    endtask

    task automatic read_reg(input logic [3:0] r, input logic [31:0] e, input string tag);
        host_write(1'b0, mk(MY_PHY, r, 1'b0));
        expect_val(1'b1, e, tag);
    endtask

    task automatic write_reg(input logic [3:0] r, input logic [31:0] d);
        host_write(1'b1, d);
        host_write(1'b0, mk(MY_PHY, r, 1'b1));
    endtask

    // monitor: pops expectations just after the falling edge
    always @(negedge clk) begin
        #1;
        while (q_exp.size() > 0) begin
            bit          s;
            logic [31:0] e, act;
            string       t;
            s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
            act = s ? data_rdata : cmd_rdata;
            vectors++;
            if (act !== e) begin
                miscompares++;
                $display("FAIL %s: %s actual=%h expected=%h", t, s ? "data" : "cmd", act, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_val(1'b0, 32'h0, "R1 cmd reset");
        expect_val(1'b1, 32'h0, "R1 data reset");
        read_reg(4'd0, 32'h3100, "R1 R4 ctrl default");

        // R2: busy bit dropped on store
        host_write(1'b0, mk(MY_PHY, 4'd2, 1'b0) | 32'hABCD_0001 & 32'hFFFF_0001);
        expect_val(1'b0, (mk(MY_PHY, 4'd2, 1'b0) | 32'hABCD_0000), "R2 cmd stored busy clear");
        expect_val(1'b1, 32'h0044, "R6 id high");
        read_reg(4'd3, 32'h1400, "R6 id low");

        // R5 and R12: status with live link
        read_reg(4'd1, 32'hFE28, "R5 status link down");
        link_up = 1'b1;
        read_reg(4'd1, 32'hFE2C, "R12 status link up");
        link_up = 1'b0;
        read_reg(4'd1, 32'hFE28, "R12 status link down again");

        // R11 then R7
        host_write(1'b1, 32'hDEAD_BEEF);
        expect_val(1'b1, 32'hDEAD_BEEF, "R11 data host write");
        read_reg(4'd7, 32'h0, "R7 unknown reg 7");
        host_write(1'b1, 32'h1111_2222);
        read_reg(4'd15, 32'h0, "R7 unknown reg 15");

        // R8: self-clearing bits masked
        write_reg(4'd0, 32'h0000_7FFF);
        read_reg(4'd0, 32'h7DFF, "R8 ctrl write masks bit 9");
        write_reg(4'd0, 32'h0000_1234);
        read_reg(4'd0, 32'h1034, "R8 ctrl write second pattern");

        // R9: soft reset restores defaults, link still live
        link_up = 1'b1;
        write_reg(4'd0, 32'h0000_8000);
        read_reg(4'd0, 32'h3100, "R9 soft reset restores ctrl");
        read_reg(4'd1, 32'hFE2C, "R9 link kept after soft reset");
        link_up = 1'b0;

        // R10: writes to other registers ignored
        write_reg(4'd0, 32'h0000_1234);
        write_reg(4'd1, 32'h0000_0000);
        read_reg(4'd1, 32'hFE28, "R10 status unchanged");
        write_reg(4'd2, 32'h0000_FFFF);
        read_reg(4'd2, 32'h0044, "R10 id unchanged");
        write_reg(4'd5, 32'h0000_0000);
        read_reg(4'd0, 32'h1034, "R10 ctrl unchanged");

        // R3: foreign address
        host_write(1'b1, 32'h0000_ABCD);
        host_write(1'b0, mk(4'd3, 4'd0, 1'b0));
        expect_val(1'b1, 32'h0000_ABCD, "R3 foreign read keeps data");
        expect_val(1'b0, mk(4'd3, 4'd0, 1'b0), "R2 foreign cmd still stored");
        host_write(1'b1, 32'h0000_0000);
        host_write(1'b0, mk(4'd3, 4'd0, 1'b1));
        read_reg(4'd0, 32'h1034, "R3 foreign write keeps ctrl");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule